// File: doc/BRIEF.md
# Serial DAC Input Register Interface

This block is the digital front end of a 12-bit voltage-output converter. A host writes to it over a three-wire serial link: an active-low frame line, a serial clock and a data line. The three pins are brought into the fast system clock through two-flop synchronisers. Edges are found by comparing each synchronised line with its value one cycle earlier. Data bits are taken on falling serial-clock edges, most significant bit first, into a 16-bit shift register.

A frame carries two bits that the block ignores, a 2-bit operating mode and a 12-bit straight-binary code. The mode and the code take effect together on exactly the sixteenth falling edge, and a one-cycle load strobe marks the change. If the frame line rises before that edge, the frame is discarded. A power-down frame updates the mode and leaves the stored code alone. The analog stage reads `code_o` and `mode_o`. A synchronous reset stands in for power-on reset.

Top module: `sdac_frontend`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `code_o` is 0, `mode_o` is 00 (normal) and `load_o` is 0.
- R2: A frame whose sixteen bits arrive MSB first loads the mode from frame bits 13:12 and the code from bits 11:0. Frame bits 15:14 have no effect.
- R3: `load_o` is high for exactly one cycle per committed frame. `code_o` and `mode_o` change only in a cycle where `load_o` is high.
- R4: If the frame line rises after fewer than sixteen falling edges, there is no load, and `code_o` and `mode_o` keep their values.
- R5: Falling edges after the sixteenth, while the frame line stays low, are ignored. They cause no second load and do not change the outputs.
- R6: Mode encoding is 00 normal, 01 power-down with low-value pull-down, 10 power-down with high-value pull-down, 11 power-down with floating output. A frame with a non-zero mode updates `mode_o` and leaves `code_o` unchanged.
- R7: If the sixteenth falling edge and the rise of the frame line reach the synchronised domain in the same cycle, the frame commits.
- R8: An aborted frame leaves no bits behind. The next complete frame loads exactly its own sixteen bits.
- R9: `load_o` rises on the third rising system-clock edge after the sixteenth serial-clock fall is applied at the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset) |
| frame_n_i | input | 1 | Asynchronous active-low frame line |
| sclk_i | input | 1 | Asynchronous serial clock; data is taken on its falling edge |
| sdata_i | input | 1 | Asynchronous serial data, MSB first |
| code_o | output | 12 | Stored converter code |
| mode_o | output | 2 | Stored operating mode |
| load_o | output | 1 | One-cycle strobe that comes with a new code and mode |

## Verification
The commit of the sixteenth bit and the rise of the frame line can land in the same system cycle. In that case the block must decide between loading the frame and discarding it. The bench provokes this by releasing the frame line at the same instant it drives the last serial-clock fall, so both pass through synchronisers of the same depth and arrive together. The scoreboard expects exactly one load carrying that frame's mode with the code unchanged. A checker property requires that no abort is flagged in a cycle that commits.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int DAC_CODE_W  = 12;
  localparam int DAC_MODE_W  = 2;
  localparam int DAC_PAD_W   = 2;
  localparam int DAC_FRAME_W = DAC_PAD_W + DAC_MODE_W + DAC_CODE_W;
  localparam int DAC_CNT_W   = $clog2(DAC_FRAME_W + 1);

  typedef enum logic [DAC_MODE_W-1:0] {
    MODE_ACTIVE  = 2'b00,
    MODE_PD_LOWR = 2'b01,
    MODE_PD_HIR  = 2'b10,
    MODE_PD_OPEN = 2'b11
  } pd_mode_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level_i;
  end

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      assign rise_o[b] = level_i[b] & ~prev_q[b];
      assign fall_o[b] = ~level_i[b] & prev_q[b];
    end
  endgenerate
endmodule

// File: rtl/sdac_frame.sv
module sdac_frame #(
  parameter int FRAME_W = sdac_pkg::DAC_FRAME_W,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_fall_i,
  input  logic               frame_rise_i,
  input  logic               sclk_fall_i,
  input  logic               din_i,
  output logic               commit_o,
  output logic               abort_o,
  output logic [FRAME_W-1:0] word_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  logic               armed_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               take;
  logic [FRAME_W-1:0] word_next;

  assign take      = sclk_fall_i & armed_q;
  assign word_next = {shreg_q[FRAME_W-2:0], din_i};
  assign commit_o  = take & (cnt_q == LAST_IDX);
  assign abort_o   = frame_rise_i & armed_q & ~commit_o;
  assign word_o    = word_next;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (commit_o) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (frame_rise_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (frame_fall_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (take) begin
      shreg_q <= word_next;
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
  import sdac_pkg::*;
#(
  parameter int CODE_W      = DAC_CODE_W,
  parameter int MODE_W      = DAC_MODE_W,
  parameter int PAD_W       = DAC_PAD_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              load_o
);
  localparam int FRAME_W = PAD_W + MODE_W + CODE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  function automatic logic [CODE_W-1:0] code_field(input logic [FRAME_W-1:0] w);
    return w[CODE_W-1:0];
  endfunction

  function automatic logic [MODE_W-1:0] mode_field(input logic [FRAME_W-1:0] w);
    return w[CODE_W +: MODE_W];
  endfunction

  function automatic logic is_active(input logic [MODE_W-1:0] m);
    return m == MODE_W'(0);
  endfunction

  logic [2:0]         pins_sync;
  logic [1:0]         rise_w;
  logic [1:0]         fall_w;
  logic               commit_w;
  logic               abort_w;
  logic [FRAME_W-1:0] word_w;
  logic [CNT_W-1:0]   cnt_w;

  logic [CODE_W-1:0]  code_q;
  logic [MODE_W-1:0]  mode_q;
  logic               load_q;

  sdac_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({frame_n_i, sclk_i, sdata_i}),
    .sync_o  (pins_sync)
  );

  sdac_edge #(.W(2)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .level_i (pins_sync[2:1]),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  sdac_frame #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
    .clk          (clk),
    .rst          (rst),
    .frame_fall_i (fall_w[1]),
    .frame_rise_i (rise_w[1]),
    .sclk_fall_i  (fall_w[0]),
    .din_i        (pins_sync[0]),
    .commit_o     (commit_w),
    .abort_o      (abort_w),
    .word_o       (word_w),
    .cnt_o        (cnt_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      mode_q <= MODE_W'(MODE_ACTIVE);
      load_q <= 1'b0;
    end else begin
      load_q <= commit_w;
      if (commit_w) begin
        mode_q <= mode_field(word_w);
        if (is_active(mode_field(word_w))) code_q <= code_field(word_w);
      end
    end
  end

  assign code_o = code_q;
  assign mode_o = mode_q;
  assign load_o = load_q;
endmodule

// File: rtl/sdac_checks.sv
module sdac_checks
  import sdac_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  commit,
  input logic                  abort,
  input logic                  load,
  input logic [DAC_CODE_W-1:0] code,
  input logic [DAC_MODE_W-1:0] mode,
  input logic [DAC_CNT_W-1:0]  cnt
);
  AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (rst)
    commit |=> load); // R2
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    load |=> !load); // R3
  AST_LOAD_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (rst)
    load |-> $past(commit)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |-> ($stable(code) && $stable(mode))); // R3
  AST_ABORT_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    abort |=> !load); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < DAC_CNT_W'(DAC_FRAME_W)); // R5
  AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (rst)
    (load && mode != '0) |-> code == $past(code)); // R6
  AST_TIE_COMMITS: assert property (@(posedge clk) disable iff (rst)
    commit |-> !abort); // R7
endmodule

bind sdac_frontend sdac_checks u_checks (
  .clk    (clk),
  .rst    (rst),
  .commit (commit_w),
  .abort  (abort_w),
  .load   (load_o),
  .code   (code_o),
  .mode   (mode_o),
  .cnt    (cnt_w)
);

// File: tb/sdac_frontend_bench.sv
module sdac_frontend_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1;
  logic        sclk = 1'b1;
  logic        sdata = 1'b0;
  logic [11:0] code_o;
  logic [1:0]  mode_o;
  logic        load_o;

  int checks = 0;
  int fails = 0;
  int r3_bad = 0;
  bit done = 1'b0;
  logic [13:0] exp_q[$];
  logic [11:0] model_code = '0;

  always #10 clk = ~clk;

  sdac_frontend u_sdac_frontend (
    .clk(clk), .rst(rst), .frame_n_i(frame_n), .sclk_i(sclk), .sdata_i(sdata),
    .code_o(code_o), .mode_o(mode_o), .load_o(load_o)
  );

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_frame(input logic [15:0] w);
    if (w[13:12] == 2'b00) model_code = w[11:0];
    exp_q.push_back({w[13:12], model_code});
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input int extra,
                      input bit coincide, input bit measure);
    frame_n = 1'b0;
    hold(4);
    for (int i = 0; i < nbits; i++) begin
      sdata = w[15-i];
      sclk = 1'b1;
      hold(4);
      sclk = 1'b0;
      if (coincide && i == nbits - 1) frame_n = 1'b1;
      if (measure && i == nbits - 1) begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 no load before third edge", load_o, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R9 load on third edge", load_o, 1'b1);
        hold(2);
      end else begin
        hold(4);
      end
    end
    for (int k = 0; k < extra; k++) begin
      sdata = ~sdata;
      sclk = 1'b1;
      hold(4);
      sclk = 1'b0;
      hold(4);
    end
    sclk = 1'b1;
    hold(4);
    frame_n = 1'b1;
    hold(8);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // scoreboard monitor
  initial begin
    logic [11:0] last_code = '0;
    logic [1:0]  last_mode = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (load_o) begin
          if (exp_q.size() == 0) begin
            check("R5 unexpected load", load_o, 1'b0);
          end else begin
            logic [13:0] e;
            e = exp_q.pop_front();
            check("R2 load code", code_o, e[11:0]);
            check("R6 load mode", mode_o, e[13:12]);
          end
        end else if (code_o !== last_code || mode_o !== last_mode) begin
          r3_bad++;
          $display("FAIL R3 outputs moved without load actual=%0h expected=%0h",
                   {mode_o, code_o}, {last_mode, last_code});
        end
        last_code = code_o;
        last_mode = mode_o;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    hold(5);
    check("R1 code in reset", code_o, 12'h000);
    check("R1 mode in reset", mode_o, 2'b00);
    check("R1 load in reset", load_o, 1'b0);
    rst = 1'b0;
    hold(1);
    check("R1 code after reset", code_o, 12'h000);
    check("R1 load after reset", load_o, 1'b0);

    // R2: pad bits set, must be ignored; R9 latency measured
    expect_frame({2'b11, 2'b00, 12'hA5C});
    send({2'b11, 2'b00, 12'hA5C}, 16, 0, 1'b0, 1'b1);
    // R6: each power-down mode keeps code
    expect_frame({2'b00, 2'b01, 12'h123});
    send({2'b00, 2'b01, 12'h123}, 16, 0, 1'b0, 1'b0);
    expect_frame({2'b10, 2'b10, 12'hFFF});
    send({2'b10, 2'b10, 12'hFFF}, 16, 0, 1'b0, 1'b0);
    expect_frame({2'b00, 2'b11, 12'h000});
    send({2'b00, 2'b11, 12'h000}, 16, 0, 1'b0, 1'b0);
    check("R6 code kept through power-down", code_o, 12'hA5C);
    expect_frame({2'b01, 2'b00, 12'h3C7});
    send({2'b01, 2'b00, 12'h3C7}, 16, 0, 1'b0, 1'b0);

    // R4: early abort
    send({2'b00, 2'b01, 12'hFFF}, 9, 0, 1'b0, 1'b0);
    check("R4 code after abort", code_o, 12'h3C7);
    check("R4 mode after abort", mode_o, 2'b00);
    // R8: full frame after abort carries only its own bits
    expect_frame({2'b00, 2'b00, 12'h001});
    send({2'b00, 2'b00, 12'h001}, 16, 0, 1'b0, 1'b0);
    check("R8 clean frame after abort", code_o, 12'h001);

    // R5: extra clocks with frame held low
    expect_frame({2'b00, 2'b00, 12'h800});
    send({2'b00, 2'b00, 12'h800}, 16, 4, 1'b0, 1'b0);
    check("R5 code after extra clocks", code_o, 12'h800);

    // R7: frame rise together with 16th fall
    expect_frame({2'b00, 2'b10, 12'h7FF});
    send({2'b00, 2'b10, 12'h7FF}, 16, 0, 1'b1, 1'b0);
    check("R7 tie commits mode", mode_o, 2'b10);

    expect_frame({2'b00, 2'b00, 12'hFFF});
    send({2'b00, 2'b00, 12'hFFF}, 16, 0, 1'b0, 1'b0);
    check("R2 full scale code", code_o, 12'hFFF);

    hold(10);
    check("R3 every expected load seen", exp_q.size(), 0);
    check("R3 no output change without load", r3_bad, 0);
    done = 1'b1;
    finish_run();
  end
endmodule